// File: doc/BRIEF.md
# Phase-Interleaved Video RAM Arbiter

This block lets a single video RAM serve two masters: a 6502-style processor and the character address generator of a CRT timing controller. A fast clock runs at the pixel rate. A phase counter divides it into processor cycles of `CYC_TICKS` ticks, and the block drives the processor clock `phi2` from that counter. With the default of 8 ticks, a 1 MHz character rate and 8 pixels per character come from an 8 MHz fast clock.

While `phi2` is low, the display side owns the RAM address. The byte at the display address is captured for the pixel shifter as `phi2` rises. While `phi2` is high, the processor address is routed to the RAM and the processor data path is opened. A processor write strobe is held back for `WE_DLY` ticks after `phi2` rises, which gives the address time to settle and decode. The strobe always ends together with the `phi2` fall.

A mode input selects a fallback in which the processor may use the RAM only while the display is blanked. In that mode `cpu_rdy` follows the inverse of display-enable, and ownership of each high phase is decided once, at the `phi2` rise.

Top module: `vram_phase_arbiter`

## Requirements
- R1: While `rst` is high, the outputs `phi2`, `char_clk`, `cpu_rdy`, `cpu_be`, `cpu_data_en`, `ram_we`, `ram_oe`, `ram_cs`, `ram_addr`, `ram_wdata`, `vid_data` and `cpu_rdata` are all 0.
- R2: After reset, `phi2` repeats with a period of `CYC_TICKS` ticks. It is low for the first `CYC_TICKS/2` ticks and high for the rest. `char_clk` is the inverse of `phi2` when `blank_only`=0 and equals `phi2` when `blank_only`=1. Both use the mode sampled one tick earlier.
- R3: Whenever `phi2` is low, the following hold: `ram_addr` equals the `crtc_addr` of the previous tick, `cpu_data_en`=0, `cpu_be`=0, `ram_we`=0 and `ram_wdata`=0.
- R4: In a high phase granted to the processor, the following hold: `ram_addr` equals the `cpu_addr` of the previous tick, and `cpu_data_en`=1 and `cpu_be`=1.
- R5: A granted high phase with `cpu_rw`=0 (write) has three effects. First, `ram_we`=1 from high-phase tick `WE_DLY` (counting from 0) up to the last high tick. Second, `ram_we`=0 in the tick where `phi2` falls. Third, `ram_wdata` carries `cpu_wdata`, and the byte lands in RAM at `cpu_addr`. `ram_oe` is always the inverse of `ram_we` after reset.
- R6: `vid_data` takes the `ram_rdata` value of the last low-phase tick, which is the byte at the display address, in the tick where `phi2` rises, and holds it at all other times. A processor write in the same cycle to that address is seen in the next cycle's byte.
- R7: `cpu_rdata` takes the RAM byte read at `cpu_addr` in the tick where `phi2` falls, but only after a granted read phase (`cpu_rw`=1). Otherwise it holds its value.
- R8: `cpu_rdy` is 1 in interleaved mode. In blanking-only mode it equals the inverse of `disp_en` sampled one tick earlier.
- R9: In blanking-only mode, the processor is granted a high phase only if `disp_en` is 0 on the tick that starts that phase. A later change of `disp_en` within the phase has no effect on the grant. An ungranted phase keeps the display address, issues no write and leaves RAM unchanged.
- R10: `ram_cs` is 1 on every tick after reset, in both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (pixel-rate) clock |
| rst | input | 1 | Synchronous active-high reset |
| blank_only | input | 1 | 0 = interleaved sharing, 1 = processor access only while blanked |
| disp_en | input | 1 | Display-enable from the CRT timing generator (1 = visible area) |
| cpu_addr | input | AW | Processor address |
| cpu_wdata | input | DW | Processor write data |
| cpu_rw | input | 1 | Processor direction, 1 = read, 0 = write |
| crtc_addr | input | AW | Display character address |
| ram_rdata | input | DW | RAM read data |
| phi2 | output | 1 | Processor clock, high = processor phase |
| char_clk | output | 1 | Display character clock |
| cpu_rdy | output | 1 | Processor ready, low = stall |
| cpu_be | output | 1 | Processor bus enable, high while it owns the RAM |
| cpu_data_en | output | 1 | Enable for the processor data buffer to the RAM |
| cpu_rdata | output | DW | Byte read back for the processor |
| ram_addr | output | AW | Multiplexed RAM address |
| ram_wdata | output | DW | RAM write data, zero outside a processor write |
| ram_we | output | 1 | RAM write enable, active high |
| ram_oe | output | 1 | RAM output enable, active high |
| ram_cs | output | 1 | RAM chip select, active high |
| vid_data | output | DW | Display byte held for the pixel shifter |

## Verification
Two events can fall in one processor cycle: the display fetch of one address in the low phase, and a processor write to the same address in the high phase. The bench sets `crtc_addr` equal to `cpu_addr` during a write cycle. It then judges that `vid_data` still shows the old byte for that cycle and the new byte one cycle later. A second coincidence is a `disp_en` change in the middle of a blanking-only high phase, which must leave the grant decided at the `phi2` rise untouched. The bench judges this by whether the write lands in RAM or not.

// File: rtl/vram_arb_pkg.sv
package vram_arb_pkg;

  typedef enum logic {
    SHARE_INTERLEAVE = 1'b0,
    SHARE_BLANK_ONLY = 1'b1
  } share_mode_e;

  typedef struct packed {
    logic phi2;       // phase the next output tick shows
    logic at_rise;    // first tick of the processor phase
    logic at_fall;    // first tick of the display phase
    logic wr_window;  // tick lies inside the delayed write window
  } phase_info_t;

endpackage

// File: rtl/vram_phase_gen.sv
module vram_phase_gen
  import vram_arb_pkg::*;
#(
  parameter int unsigned CYC_TICKS = 8,
  parameter int unsigned WE_DLY    = 1
) (
  input  logic        clk,
  input  logic        rst,
  output phase_info_t ph
);
  localparam int unsigned HALF = CYC_TICKS / 2;
  localparam int unsigned CW   = $clog2(CYC_TICKS);
  localparam logic [CW-1:0] LAST  = CW'(CYC_TICKS - 1);
  localparam logic [CW-1:0] HIGH0 = CW'(HALF);
  localparam logic [CW-1:0] WROPN = CW'(HALF + WE_DLY);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  always_comb begin
    ph.phi2      = (cnt >= HIGH0);
    ph.at_rise   = (cnt == HIGH0);
    ph.at_fall   = (cnt == '0);
    ph.wr_window = (cnt >= WROPN);
  end
endmodule

// File: rtl/vram_owner_sel.sv
module vram_owner_sel
  import vram_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        phi2_nxt,
  input  logic        at_rise,
  input  share_mode_e mode,
  input  logic        disp_en,
  output logic        own,
  output logic        rdy_nxt
);
  logic grant_q;
  logic grant_now;
  logic may_enter;

  always_comb begin
    may_enter = (mode == SHARE_INTERLEAVE) || !disp_en;
    grant_now = at_rise ? may_enter : grant_q;
    own       = phi2_nxt && grant_now;
    rdy_nxt   = may_enter;
  end

  always_ff @(posedge clk) begin
    if (rst) grant_q <= 1'b0;
    else     grant_q <= grant_now;
  end
endmodule

// File: rtl/vram_bus_mux.sv
module vram_bus_mux #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          own,
  input  logic          wr_window,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rw,
  input  logic [AW-1:0] crtc_addr,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_oe,
  output logic          cpu_data_en,
  output logic          cpu_be,
  output logic          cpu_rd_q
);
  logic          wr_cyc;
  logic          we_nxt;
  logic [AW-1:0] addr_nxt;
  logic [DW-1:0] wd_nxt;

  always_comb begin
    wr_cyc   = own && !cpu_rw;
    we_nxt   = wr_cyc && wr_window;
    addr_nxt = own ? cpu_addr : crtc_addr;
    wd_nxt   = wr_cyc ? cpu_wdata : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_addr    <= '0;
      ram_wdata   <= '0;
      ram_we      <= 1'b0;
      ram_oe      <= 1'b0;
      cpu_data_en <= 1'b0;
      cpu_be      <= 1'b0;
      cpu_rd_q    <= 1'b0;
    end else begin
      ram_addr    <= addr_nxt;
      ram_wdata   <= wd_nxt;
      ram_we      <= we_nxt;
      ram_oe      <= !we_nxt;
      cpu_data_en <= own;
      cpu_be      <= own;
      cpu_rd_q    <= own && cpu_rw;
    end
  end
endmodule

// File: rtl/vram_rd_latch.sv
module vram_rd_latch #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          at_rise,
  input  logic          at_fall,
  input  logic          cpu_rd_q,
  input  logic [DW-1:0] ram_rdata,
  output logic [DW-1:0] vid_data,
  output logic [DW-1:0] cpu_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vid_data  <= '0;
      cpu_rdata <= '0;
    end else begin
      if (at_rise)             vid_data  <= ram_rdata;
      if (at_fall && cpu_rd_q) cpu_rdata <= ram_rdata;
    end
  end
endmodule

// File: rtl/vram_phase_arbiter.sv
module vram_phase_arbiter
  import vram_arb_pkg::*;
#(
  parameter int unsigned AW        = 13,
  parameter int unsigned DW        = 8,
  parameter int unsigned CYC_TICKS = 8,
  parameter int unsigned WE_DLY    = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          blank_only,
  input  logic          disp_en,
  input  logic [AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  input  logic          cpu_rw,
  input  logic [AW-1:0] crtc_addr,
  input  logic [DW-1:0] ram_rdata,
  output logic          phi2,
  output logic          char_clk,
  output logic          cpu_rdy,
  output logic          cpu_be,
  output logic          cpu_data_en,
  output logic [DW-1:0] cpu_rdata,
  output logic [AW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic          ram_we,
  output logic          ram_oe,
  output logic          ram_cs,
  output logic [DW-1:0] vid_data
);
  phase_info_t ph;
  share_mode_e mode;
  logic        own;
  logic        rdy_nxt;
  logic        cpu_rd_q;

  assign mode = share_mode_e'(blank_only);

  vram_phase_gen #(.CYC_TICKS(CYC_TICKS), .WE_DLY(WE_DLY)) u_phase (
    .clk(clk), .rst(rst), .ph(ph)
  );

  vram_owner_sel u_owner (
    .clk(clk), .rst(rst), .phi2_nxt(ph.phi2), .at_rise(ph.at_rise),
    .mode(mode), .disp_en(disp_en), .own(own), .rdy_nxt(rdy_nxt)
  );

  vram_bus_mux #(.AW(AW), .DW(DW)) u_mux (
    .clk(clk), .rst(rst), .own(own), .wr_window(ph.wr_window),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rw(cpu_rw),
    .crtc_addr(crtc_addr), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_we(ram_we), .ram_oe(ram_oe), .cpu_data_en(cpu_data_en),
    .cpu_be(cpu_be), .cpu_rd_q(cpu_rd_q)
  );

  vram_rd_latch #(.DW(DW)) u_latch (
    .clk(clk), .rst(rst), .at_rise(ph.at_rise), .at_fall(ph.at_fall),
    .cpu_rd_q(cpu_rd_q), .ram_rdata(ram_rdata),
    .vid_data(vid_data), .cpu_rdata(cpu_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phi2     <= 1'b0;
      char_clk <= 1'b0;
      cpu_rdy  <= 1'b0;
      ram_cs   <= 1'b0;
    end else begin
      phi2     <= ph.phi2;
      char_clk <= (mode == SHARE_BLANK_ONLY) ? ph.phi2 : !ph.phi2;
      cpu_rdy  <= rdy_nxt;
      ram_cs   <= 1'b1;
    end
  end
endmodule

// File: rtl/vram_phase_arbiter_chk.sv
module vram_phase_arbiter_chk #(
  parameter int unsigned AW        = 13,
  parameter int unsigned DW        = 8,
  parameter int unsigned CYC_TICKS = 8,
  parameter int unsigned WE_DLY    = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          blank_only,
  input logic          disp_en,
  input logic [AW-1:0] cpu_addr,
  input logic [DW-1:0] cpu_wdata,
  input logic          cpu_rw,
  input logic [AW-1:0] crtc_addr,
  input logic [DW-1:0] ram_rdata,
  input logic          phi2,
  input logic          char_clk,
  input logic          cpu_rdy,
  input logic          cpu_be,
  input logic          cpu_data_en,
  input logic [DW-1:0] cpu_rdata,
  input logic [AW-1:0] ram_addr,
  input logic [DW-1:0] ram_wdata,
  input logic          ram_we,
  input logic          ram_oe,
  input logic          ram_cs,
  input logic [DW-1:0] vid_data
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  p_char_clk_r2: assert property (@(posedge clk) disable iff (rst || !armed)
    char_clk == ($past(blank_only) ? phi2 : !phi2));
  p_disp_addr_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    !phi2 |-> (ram_addr == $past(crtc_addr)));
  p_cpu_off_low_r3: assert property (@(posedge clk) disable iff (rst || !armed)
    !phi2 |-> (!cpu_data_en && !cpu_be && !ram_we && ram_wdata == '0));
  p_cpu_addr_r4: assert property (@(posedge clk) disable iff (rst || !armed)
    cpu_be |-> (ram_addr == $past(cpu_addr) && cpu_data_en));
  p_we_write_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    ram_we |-> (!$past(cpu_rw) && ram_wdata == $past(cpu_wdata) && cpu_be));
  p_we_end_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    $fell(phi2) |-> !ram_we);
  p_oe_we_r5: assert property (@(posedge clk) disable iff (rst || !armed)
    ram_oe == !ram_we);
  generate
    if (WE_DLY > 0) begin : g_dly
      p_we_late_r5: assert property (@(posedge clk) disable iff (rst || !armed)
        $rose(phi2) |-> !ram_we);
    end
  endgenerate
  p_vid_take_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    $rose(phi2) |-> (vid_data == $past(ram_rdata)));
  p_vid_hold_r6: assert property (@(posedge clk) disable iff (rst || !armed)
    !$rose(phi2) |-> $stable(vid_data));
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst || !armed)
    !$fell(phi2) |-> $stable(cpu_rdata));
  p_rdy_blank_r8: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(blank_only) && $past(disp_en)) |-> !cpu_rdy);
  p_grant_fixed_r9: assert property (@(posedge clk) disable iff (rst || !armed)
    (phi2 && $past(phi2)) |-> $stable(cpu_be));
  p_cs_r10: assert property (@(posedge clk) disable iff (rst || !armed)
    ram_cs);
endmodule

bind vram_phase_arbiter vram_phase_arbiter_chk #(
  .AW(AW), .DW(DW), .CYC_TICKS(CYC_TICKS), .WE_DLY(WE_DLY)
) u_chk (.*);

// File: tb/tb_vram_phase_arbiter.sv
module tb_vram_phase_arbiter;
  localparam int AW = 8, DW = 8, CYC = 8, HALF = 4, WE_DLY = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic blank_only = 1'b0, disp_en = 1'b0, cpu_rw = 1'b1;
  logic [AW-1:0] cpu_addr = '0, crtc_addr = '0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] ram_rdata;
  logic phi2, char_clk, cpu_rdy, cpu_be, cpu_data_en, ram_we, ram_oe, ram_cs;
  logic [DW-1:0] cpu_rdata, ram_wdata, vid_data;
  logic [AW-1:0] ram_addr;

  logic [DW-1:0] mem [1<<AW];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = !clk;

  vram_phase_arbiter #(.AW(AW), .DW(DW), .CYC_TICKS(CYC), .WE_DLY(WE_DLY)) dut (.*);

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_cs && ram_we) mem[ram_addr] <= ram_wdata;

  // reference state
  int ph = 0;
  logic m_g = 0, m_rd = 0, m_own, m_phi2, m_we, m_char, m_rdy;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wd, m_vid = '0, m_cpu = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (phase %0d)", tag, act, exp, ph);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    m_phi2 = (ph >= HALF);
    if (ph == HALF) begin
      m_vid = mem[m_addr];
      m_g   = !blank_only || !disp_en;
    end
    if (ph == 0 && m_rd) m_cpu = mem[m_addr];
    m_own  = m_phi2 && m_g;
    m_addr = m_own ? cpu_addr : crtc_addr;
    m_we   = m_own && !cpu_rw && (ph >= HALF + WE_DLY);
    m_wd   = (m_own && !cpu_rw) ? cpu_wdata : '0;
    m_rd   = m_own && cpu_rw;
    m_char = blank_only ? m_phi2 : !m_phi2;
    m_rdy  = !blank_only || !disp_en;
    ph = (ph + 1) % CYC;
    @(negedge clk);
    chk("R2 phi2", phi2, m_phi2);
    chk("R2 char_clk", char_clk, m_char);
    if (m_own) begin
      chk("R4 ram_addr", ram_addr, m_addr);
      chk("R4 cpu_be", cpu_be, 1);
      chk("R4 cpu_data_en", cpu_data_en, 1);
    end else begin
      chk("R3 ram_addr", ram_addr, m_addr);
      chk("R3 cpu_be", cpu_be, 0);
      chk("R3 cpu_data_en", cpu_data_en, 0);
    end
    chk("R5 ram_we", ram_we, m_we);
    chk("R5 ram_wdata", ram_wdata, m_wd);
    chk("R5 ram_oe", ram_oe, !m_we);
    chk("R6 vid_data", vid_data, m_vid);
    chk("R7 cpu_rdata", cpu_rdata, m_cpu);
    chk("R8 cpu_rdy", cpu_rdy, m_rdy);
    chk("R10 ram_cs", ram_cs, 1);
  endtask

  task automatic cpu_cycle(input bit bo, input bit de, input bit rw,
                           input logic [AW-1:0] ca, input logic [AW-1:0] cr,
                           input logic [DW-1:0] wd, input int flip_at);
    blank_only = bo; disp_en = de; cpu_rw = rw;
    cpu_addr = ca; crtc_addr = cr; cpu_wdata = wd;
    for (int t = 0; t < CYC; t++) begin
      if (t == flip_at) disp_en = !disp_en;
      tick();
    end
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 7 + 3);
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1 phi2", phi2, 0);         chk("R1 char_clk", char_clk, 0);
    chk("R1 cpu_rdy", cpu_rdy, 0);   chk("R1 cpu_be", cpu_be, 0);
    chk("R1 cpu_data_en", cpu_data_en, 0);
    chk("R1 ram_we", ram_we, 0);     chk("R1 ram_oe", ram_oe, 0);
    chk("R1 ram_cs", ram_cs, 0);     chk("R1 ram_addr", ram_addr, 0);
    chk("R1 ram_wdata", ram_wdata, 0);
    chk("R1 vid_data", vid_data, 0); chk("R1 cpu_rdata", cpu_rdata, 0);
    rst = 1'b0;

    // sweep of mode, display-enable, direction and addresses
    for (int bo = 0; bo < 2; bo++)
      for (int de = 0; de < 2; de++)
        for (int rw = 0; rw < 2; rw++)
          for (int i = 0; i < 4; i++)
            cpu_cycle(bo[0], de[0], rw[0], AW'(i * 37 + bo * 5 + de * 11 + rw * 3 + 1),
                      AW'(i * 53 + 200), DW'(i * 29 + bo * 64 + de * 16 + 5), CYC);

    // read-back of a written byte (R5, R7)
    cpu_cycle(0, 1, 0, 8'h41, 8'h90, 8'hA7, CYC);
    chk("R5 byte landed", mem[8'h41], 8'hA7);
    cpu_cycle(0, 1, 1, 8'h41, 8'h90, 8'h00, CYC);
    cpu_cycle(0, 1, 1, 8'h42, 8'h90, 8'h00, CYC);
    chk("R7 read-back", cpu_rdata, 8'hA7);

    // same-cycle display fetch and write to one address (R6)
    begin
      logic [DW-1:0] old_b;
      old_b = mem[8'h20];
      cpu_cycle(0, 1, 0, 8'h20, 8'h20, 8'hC3, CYC);
      chk("R6 same-cycle old byte", vid_data, old_b);
      cpu_cycle(0, 1, 1, 8'h33, 8'h20, 8'h00, CYC);
      chk("R6 next-cycle new byte", vid_data, 8'hC3);
    end

    // grant fixed at phi2 rise (R9)
    cpu_cycle(1, 0, 0, 8'h55, 8'h91, 8'h6E, HALF + 1);
    chk("R9 late disp_en ignored, write kept", mem[8'h55], 8'h6E);
    begin
      logic [DW-1:0] keep;
      keep = mem[8'h56];
      cpu_cycle(1, 1, 0, 8'h56, 8'h92, 8'h17, HALF + 1);
      chk("R9 late blank ignored, no write", mem[8'h56], keep);
      cpu_cycle(1, 1, 0, 8'h56, 8'h92, 8'h18, CYC);
      chk("R9 visible write blocked", mem[8'h56], keep);
    end
    cpu_cycle(0, 1, 1, 8'h10, 8'h11, 8'h00, CYC);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R2 watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule